// File: doc/BRIEF.md
# Per-Sink Trace ID Filter

This block sits between one shared trace stream and two trace-capture sinks. Every incoming beat carries a 7-bit trace ID. Each sink has its own 128-bit allowlist with one bit per ID. A beat reaches a sink only when that sink's bit for the beat's ID is set. Otherwise that sink never sees the beat. The two allowlists are independent, so an ID can go to one sink, to both, or to neither.

Software can load and inspect the allowlists through a small word-addressed register port. Trace producers use a separate command port to claim or release an ID on a given sink. This port keeps an 8-bit reference count per (sink, ID) pair. An ID therefore stays enabled for as long as at least one producer still holds it.

The trace input uses a valid/ready handshake. Each sink output is a registered valid/ready stage. A stalled sink holds up only the beats it is meant to receive.

Top module: `trace_id_filter`

## Requirements
- R1: While `rst` is high, at a rising edge all allowlist bits clear, all reference counts clear, both `out_valid` bits go low and `cmd_err` goes low.
- R2: Register word address k (0 to 7) holds bits of sink k/4. Bit b of word k is the ID 32*(k mod 4)+b. A write replaces the whole word. A read returns the word's value before the edge on `reg_rdata` at the edge after `reg_rd_en`.
- R3: A beat accepted with ID n is loaded into the output of each sink whose bit n is set. It appears on that sink's `out_valid`, `out_id` and `out_data` at the next edge. Sinks whose bit is clear do not receive it.
- R4: `in_ready` is low only when a sink that wants the current ID still holds an unaccepted beat (`out_valid` high and `out_ready` low). A stalled sink that does not want the ID does not block the beat. A beat that no sink wants is accepted and discarded.
- R5: While `out_valid` is high and `out_ready` is low, the sink output keeps its beat unchanged.
- R6: A command with `cmd_op`=1 (enable) on (sink, ID) increments that pair's count and sets the allowlist bit.
- R7: A command with `cmd_op`=0 (disable) decrements the count. The bit clears only when the count reaches zero. No other bit changes.
- R8: A disable on a pair whose count is zero changes nothing and raises `cmd_err` for exactly one cycle, at the edge after the command.
- R9: An enable on a pair whose count is 255 leaves the count at 255 and raises `cmd_err` for one cycle.
- R10: The command and register state of one sink never alters the other sink's allowlist or counts.
- R11: Forwarding uses the allowlist held before the acceptance edge. A command in the same cycle as a beat affects only later beats.
- R12: When a register write and a command hit the same word in one cycle, the command's bit update overrides the written value for that bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 1 | 1 = enable, 0 = disable |
| cmd_sink | input | 1 | Command target sink |
| cmd_id | input | 7 | Command trace ID |
| cmd_err | output | 1 | One-cycle error pulse (underflow or saturation) |
| in_valid | input | 1 | Trace beat valid |
| in_ready | output | 1 | Trace beat accepted when high with `in_valid` |
| in_id | input | 7 | Trace ID of the beat |
| in_data | input | 32 | Beat payload |
| out_valid | output | 2 | Per-sink beat valid |
| out_ready | input | 2 | Per-sink ready |
| out_id | output | 14 | Per-sink beat ID, sink s at bits [7s+6:7s] |
| out_data | output | 64 | Per-sink payload, sink s at bits [32s+31:32s] |

## Verification
Forwarded beats, command errors and read data all appear one edge after the cycle that caused them. The bench drives inputs on the falling edge and samples one falling edge later, after exactly one rising edge. `in_ready` depends on the current inputs and the held outputs, so the bench reads it 1 ns after driving, before the edge. Allowlist effects of commands and writes are checked at the next beat or the next register read. This keeps them within the cycle that R11 and R2 allow.

// File: rtl/tidf_pkg.sv
package tidf_pkg;
  typedef enum logic {
    CMD_DISABLE = 1'b0,
    CMD_ENABLE  = 1'b1
  } cmd_op_e;
endpackage

// File: rtl/tidf_refcnt.sv
module tidf_refcnt
  import tidf_pkg::*;
#(
  parameter int NUM_SINKS = 2,
  parameter int ID_W      = 7,
  parameter int CNT_W     = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cmd_valid,
  input  cmd_op_e              cmd_op,
  input  logic [((NUM_SINKS > 1) ? $clog2(NUM_SINKS) : 1)-1:0] cmd_sink,
  input  logic [ID_W-1:0]      cmd_id,
  output logic                 set_bit,
  output logic                 clr_bit,
  output logic                 err_o
);
  localparam int SINK_W  = (NUM_SINKS > 1) ? $clog2(NUM_SINKS) : 1;
  localparam int NUM_IDS = 1 << ID_W;
  localparam int ENTRIES = NUM_SINKS * NUM_IDS;
  localparam int IDX_W   = SINK_W + ID_W;

  logic [CNT_W-1:0] cnt_q [ENTRIES];
  logic [IDX_W-1:0] idx;
  logic [CNT_W-1:0] cur;
  logic             bad;
  logic             err_q;

  assign idx = {cmd_sink, cmd_id};
  assign cur = cnt_q[idx];

  always_comb begin
    bad     = 1'b0;
    set_bit = 1'b0;
    clr_bit = 1'b0;
    if (cmd_valid) begin
      if (cmd_op == CMD_ENABLE) begin
        bad     = &cur;
        set_bit = 1'b1;
      end else begin
        bad     = (cur == '0);
        clr_bit = (cur == CNT_W'(1));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      err_q <= 1'b0;
      for (int i = 0; i < ENTRIES; i++) cnt_q[i] <= '0;
    end else begin
      err_q <= bad;
      if (cmd_valid && !bad) begin
        if (cmd_op == CMD_ENABLE) cnt_q[idx] <= cur + CNT_W'(1);
        else                      cnt_q[idx] <= cur - CNT_W'(1);
      end
    end
  end

  assign err_o = err_q;
endmodule

// File: rtl/tidf_allow_bank.sv
module tidf_allow_bank #(
  parameter int NUM_SINKS = 2,
  parameter int ID_W      = 7,
  parameter int REG_W     = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [((NUM_SINKS > 1) ? $clog2(NUM_SINKS) : 1) + $clog2((1 << ID_W) / REG_W)-1:0] addr,
  input  logic [REG_W-1:0]     wdata,
  output logic [REG_W-1:0]     rdata,
  input  logic [((NUM_SINKS > 1) ? $clog2(NUM_SINKS) : 1)-1:0] cmd_sink,
  input  logic [ID_W-1:0]      cmd_id,
  input  logic                 set_bit,
  input  logic                 clr_bit,
  output logic [NUM_SINKS*(1 << ID_W)-1:0] bitmap_o
);
  localparam int SINK_W      = (NUM_SINKS > 1) ? $clog2(NUM_SINKS) : 1;
  localparam int NUM_IDS     = 1 << ID_W;
  localparam int WORDS       = NUM_IDS / REG_W;
  localparam int ADDR_W      = SINK_W + $clog2(WORDS);
  localparam int TOTAL_WORDS = NUM_SINKS * WORDS;
  localparam int BITS        = NUM_SINKS * NUM_IDS;

  logic [BITS-1:0]          bm_q, bm_d;
  logic [REG_W-1:0]         rd_word, rdata_q;
  logic [SINK_W+ID_W-1:0]   cidx;

  assign cidx = {cmd_sink, cmd_id};

  always_comb begin
    bm_d    = bm_q;
    rd_word = '0;
    for (int k = 0; k < TOTAL_WORDS; k++) begin
      if (addr == ADDR_W'(k)) begin
        rd_word = bm_q[k*REG_W +: REG_W];
        if (wr_en) bm_d[k*REG_W +: REG_W] = wdata;
      end
    end
    if (set_bit) bm_d[cidx] = 1'b1;
    if (clr_bit) bm_d[cidx] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bm_q    <= '0;
      rdata_q <= '0;
    end else begin
      bm_q <= bm_d;
      if (rd_en) rdata_q <= rd_word;
    end
  end

  assign bitmap_o = bm_q;
  assign rdata    = rdata_q;
endmodule

// File: rtl/tidf_sink_port.sv
module tidf_sink_port #(
  parameter int ID_W   = 7,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ID_W-1:0]   in_id,
  input  logic [DATA_W-1:0] in_data,
  output logic              free,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ID_W-1:0]   out_id,
  output logic [DATA_W-1:0] out_data
);
  logic              valid_q;
  logic [ID_W-1:0]   id_q;
  logic [DATA_W-1:0] data_q;

  assign free = !valid_q || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      id_q    <= '0;
      data_q  <= '0;
    end else if (load) begin
      valid_q <= 1'b1;
      id_q    <= in_id;
      data_q  <= in_data;
    end else if (out_ready) begin
      valid_q <= 1'b0;
    end
  end

  assign out_valid = valid_q;
  assign out_id    = id_q;
  assign out_data  = data_q;
endmodule

// File: rtl/trace_id_filter.sv
module trace_id_filter
  import tidf_pkg::*;
#(
  parameter int NUM_SINKS = 2,
  parameter int ID_W      = 7,
  parameter int REG_W     = 32,
  parameter int DATA_W    = 32,
  parameter int CNT_W     = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        reg_wr_en,
  input  logic                        reg_rd_en,
  input  logic [((NUM_SINKS > 1) ? $clog2(NUM_SINKS) : 1) + $clog2((1 << ID_W) / REG_W)-1:0] reg_addr,
  input  logic [REG_W-1:0]            reg_wdata,
  output logic [REG_W-1:0]            reg_rdata,
  input  logic                        cmd_valid,
  input  logic                        cmd_op,
  input  logic [((NUM_SINKS > 1) ? $clog2(NUM_SINKS) : 1)-1:0] cmd_sink,
  input  logic [ID_W-1:0]             cmd_id,
  output logic                        cmd_err,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic [ID_W-1:0]             in_id,
  input  logic [DATA_W-1:0]           in_data,
  output logic [NUM_SINKS-1:0]        out_valid,
  input  logic [NUM_SINKS-1:0]        out_ready,
  output logic [NUM_SINKS*ID_W-1:0]   out_id,
  output logic [NUM_SINKS*DATA_W-1:0] out_data
);
  localparam int NUM_IDS = 1 << ID_W;

  logic [NUM_SINKS*NUM_IDS-1:0] bitmap;
  logic [NUM_SINKS-1:0]         want, free, load;
  logic                         set_bit, clr_bit, accept;

  tidf_refcnt #(
    .NUM_SINKS(NUM_SINKS), .ID_W(ID_W), .CNT_W(CNT_W)
  ) u_refcnt (
    .clk(clk), .rst(rst),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op_e'(cmd_op)),
    .cmd_sink(cmd_sink), .cmd_id(cmd_id),
    .set_bit(set_bit), .clr_bit(clr_bit), .err_o(cmd_err)
  );

  tidf_allow_bank #(
    .NUM_SINKS(NUM_SINKS), .ID_W(ID_W), .REG_W(REG_W)
  ) u_bank (
    .clk(clk), .rst(rst),
    .wr_en(reg_wr_en), .rd_en(reg_rd_en), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata),
    .cmd_sink(cmd_sink), .cmd_id(cmd_id),
    .set_bit(set_bit), .clr_bit(clr_bit),
    .bitmap_o(bitmap)
  );

  always_comb begin
    in_ready = 1'b1;
    for (int s = 0; s < NUM_SINKS; s++) begin
      want[s] = bitmap[s*NUM_IDS + int'(in_id)];
      if (want[s] && !free[s]) in_ready = 1'b0;
    end
  end

  assign accept = in_valid && in_ready;

  for (genvar s = 0; s < NUM_SINKS; s++) begin : g_sink
    assign load[s] = accept && want[s];
    tidf_sink_port #(
      .ID_W(ID_W), .DATA_W(DATA_W)
    ) u_port (
      .clk(clk), .rst(rst),
      .load(load[s]), .in_id(in_id), .in_data(in_data),
      .free(free[s]),
      .out_valid(out_valid[s]), .out_ready(out_ready[s]),
      .out_id(out_id[s*ID_W +: ID_W]),
      .out_data(out_data[s*DATA_W +: DATA_W])
    );
  end
endmodule

// File: rtl/tidf_checker.sv
module tidf_checker #(
  parameter int NUM_SINKS = 2,
  parameter int ID_W      = 7,
  parameter int DATA_W    = 32
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        in_valid,
  input logic                        in_ready,
  input logic [ID_W-1:0]             in_id,
  input logic [NUM_SINKS-1:0]        out_valid,
  input logic [NUM_SINKS-1:0]        out_ready,
  input logic [NUM_SINKS*ID_W-1:0]   out_id,
  input logic [NUM_SINKS*DATA_W-1:0] out_data,
  input logic                        cmd_valid,
  input logic                        cmd_op,
  input logic [((NUM_SINKS > 1) ? $clog2(NUM_SINKS) : 1)-1:0] cmd_sink,
  input logic [ID_W-1:0]             cmd_id,
  input logic                        cmd_err,
  input logic [NUM_SINKS*(1 << ID_W)-1:0] bitmap
);
  localparam int SINK_W  = (NUM_SINKS > 1) ? $clog2(NUM_SINKS) : 1;
  localparam int NUM_IDS = 1 << ID_W;

  logic [SINK_W+ID_W-1:0] cidx;
  assign cidx = {cmd_sink, cmd_id};

  for (genvar s = 0; s < NUM_SINKS; s++) begin : g_chk
    p_out_hold_r5: assert property (@(posedge clk) disable iff (rst)
      out_valid[s] && !out_ready[s] |=>
        out_valid[s] && $stable(out_data[s*DATA_W +: DATA_W]));

    p_fwd_r3: assert property (@(posedge clk) disable iff (rst)
      in_valid && in_ready && bitmap[s*NUM_IDS + int'(in_id)] |=>
        out_valid[s] && (out_id[s*ID_W +: ID_W] == $past(in_id)));
  end

  p_idle_ready_r4: assert property (@(posedge clk) disable iff (rst)
    (out_valid == '0) |-> in_ready);

  p_err_after_cmd_r8: assert property (@(posedge clk) disable iff (rst)
    cmd_err |-> $past(cmd_valid));

  p_enable_sets_r6: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_op |=> bitmap[$past(cidx)]);
endmodule

bind trace_id_filter tidf_checker #(
  .NUM_SINKS(NUM_SINKS), .ID_W(ID_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst(rst),
  .in_valid(in_valid), .in_ready(in_ready), .in_id(in_id),
  .out_valid(out_valid), .out_ready(out_ready),
  .out_id(out_id), .out_data(out_data),
  .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .cmd_sink(cmd_sink), .cmd_id(cmd_id), .cmd_err(cmd_err),
  .bitmap(bitmap)
);

// File: tb/trace_id_filter_tb.sv
module trace_id_filter_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr_en = 0, reg_rd_en = 0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        cmd_valid = 0, cmd_op = 0, cmd_sink = 0;
  logic [6:0]  cmd_id = '0;
  logic        cmd_err;
  logic        in_valid = 0, in_ready;
  logic [6:0]  in_id = '0;
  logic [31:0] in_data = '0;
  logic [1:0]  out_valid, out_ready = 2'b11;
  logic [13:0] out_id;
  logic [63:0] out_data;

  int total = 0, bad = 0;

  always #5 clk = ~clk;

  trace_id_filter u_dut (
    .clk(clk), .rst(rst),
    .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_sink(cmd_sink),
    .cmd_id(cmd_id), .cmd_err(cmd_err),
    .in_valid(in_valid), .in_ready(in_ready), .in_id(in_id), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_id(out_id), .out_data(out_data)
  );

  // {id[6:0], forward to sink0, forward to sink1}
  localparam logic [8:0] VEC [7] = '{
    {7'd5,   1'b1, 1'b1},
    {7'd0,   1'b1, 1'b0},
    {7'd67,  1'b1, 1'b0},
    {7'd127, 1'b0, 1'b1},
    {7'd1,   1'b0, 1'b0},
    {7'd96,  1'b0, 1'b0},
    {7'd32,  1'b0, 1'b0}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic reg_write(logic [2:0] a, logic [31:0] d);
    @(negedge clk); reg_wr_en = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr_en = 0;
  endtask

  task automatic reg_read(logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd_en = 1; reg_addr = a;
    @(negedge clk); reg_rd_en = 0; d = reg_rdata;
  endtask

  task automatic command(logic sink, logic [6:0] id, logic op, output logic err);
    @(negedge clk); cmd_valid = 1; cmd_sink = sink; cmd_id = id; cmd_op = op;
    @(negedge clk); cmd_valid = 0; err = cmd_err;
  endtask

  task automatic send_beat(logic [6:0] id);
    @(negedge clk); in_valid = 1; in_id = id; in_data = 32'hA500_0000 | 32'(id);
    @(negedge clk); in_valid = 0;
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    logic        e;

    do_reset();
    // R1: reset state
    check("R1 out_valid", 32'(out_valid), 0);
    check("R1 cmd_err", 32'(cmd_err), 0);
    for (int k = 0; k < 8; k++) begin
      reg_read(3'(k), rd);
      check("R1 allowlist word clear", rd, 0);
    end

    // R2: configure by register writes and read back
    reg_write(3'd0, 32'h0000_0021);   // sink0 ids 0,5
    reg_write(3'd2, 32'h0000_0008);   // sink0 id 67
    reg_write(3'd4, 32'h0000_0020);   // sink1 id 5
    reg_write(3'd7, 32'h8000_0000);   // sink1 id 127
    reg_read(3'd7, rd); check("R2 readback word7", rd, 32'h8000_0000);
    reg_read(3'd2, rd); check("R2 readback word2", rd, 32'h0000_0008);
    reg_read(3'd1, rd); check("R2 untouched word1", rd, 0);

    // R3 / R10: table-driven forwarding
    for (int i = 0; i < 7; i++) begin
      send_beat(VEC[i][8:2]);
      check("R3 sink0 valid", 32'(out_valid[0]), 32'(VEC[i][1]));
      check("R10 sink1 valid", 32'(out_valid[1]), 32'(VEC[i][0]));
      if (VEC[i][1]) check("R3 sink0 data", out_data[31:0], 32'hA500_0000 | 32'(VEC[i][8:2]));
      if (VEC[i][0]) check("R3 sink1 id", 32'(out_id[13:7]), 32'(VEC[i][8:2]));
    end
    @(negedge clk);

    // R4 / R5: backpressure
    out_ready = 2'b10;
    send_beat(7'd0);
    check("R3 sink0 loaded", 32'(out_valid[0]), 1);
    in_valid = 1; in_id = 7'd127; in_data = 32'hB1;
    #1 check("R4 unwanted stall ignored", 32'(in_ready), 1);
    @(negedge clk); in_valid = 0;
    check("R4 sink1 got beat", out_data[63:32], 32'hB1);
    check("R5 sink0 held", out_data[31:0], 32'hA500_0000);
    in_valid = 1; in_id = 7'd5; in_data = 32'hB2;
    #1 check("R4 wanted stall blocks", 32'(in_ready), 0);
    @(negedge clk);
    check("R5 sink0 stable", out_data[31:0], 32'hA500_0000);
    check("R5 sink0 valid held", 32'(out_valid[0]), 1);
    out_ready = 2'b11;
    #1 check("R4 ready after release", 32'(in_ready), 1);
    @(negedge clk); in_valid = 0;
    check("R4 both got beat s0", out_data[31:0], 32'hB2);
    check("R4 both got beat s1", out_data[63:32], 32'hB2);

    // R6 / R7 / R8: reference counting
    do_reset();
    command(1'b0, 7'd9, 1'b1, e); check("R6 no err", 32'(e), 0);
    reg_read(3'd0, rd); check("R6 bit set", rd, 32'h200);
    command(1'b0, 7'd9, 1'b1, e);
    command(1'b0, 7'd9, 1'b0, e); check("R7 no err", 32'(e), 0);
    reg_read(3'd0, rd); check("R7 bit kept while held", rd, 32'h200);
    command(1'b0, 7'd9, 1'b0, e);
    reg_read(3'd0, rd); check("R7 bit cleared at zero", rd, 0);
    command(1'b0, 7'd9, 1'b0, e); check("R8 underflow err", 32'(e), 1);
    @(negedge clk); check("R8 err one cycle", 32'(cmd_err), 0);
    reg_read(3'd0, rd); check("R8 bit unchanged", rd, 0);

    // R10: bank independence
    command(1'b1, 7'd9, 1'b1, e);
    reg_read(3'd4, rd); check("R10 sink1 bit set", rd, 32'h200);
    reg_read(3'd0, rd); check("R10 sink0 untouched", rd, 0);

    // R9: saturation at 255
    for (int i = 0; i < 255; i++) command(1'b1, 7'd40, 1'b1, e);
    check("R9 no err at 255th", 32'(e), 0);
    command(1'b1, 7'd40, 1'b1, e); check("R9 saturate err", 32'(e), 1);
    command(1'b1, 7'd40, 1'b0, e); check("R9 dec no err", 32'(e), 0);
    reg_read(3'd5, rd); check("R9 bit still set", rd, 32'h100);

    // R11: same-cycle command does not affect the beat
    @(negedge clk);
    cmd_valid = 1; cmd_sink = 0; cmd_id = 7'd12; cmd_op = 1;
    in_valid = 1; in_id = 7'd12; in_data = 32'hC0;
    @(negedge clk); cmd_valid = 0; in_valid = 0;
    check("R11 old allowlist used", 32'(out_valid[0]), 0);
    send_beat(7'd12);
    check("R11 new allowlist used", 32'(out_valid[0]), 1);

    // R12: command beats register write in same cycle
    @(negedge clk);
    reg_wr_en = 1; reg_addr = 3'd0; reg_wdata = 32'h0;
    cmd_valid = 1; cmd_sink = 0; cmd_id = 7'd2; cmd_op = 1;
    @(negedge clk); reg_wr_en = 0; cmd_valid = 0;
    reg_read(3'd0, rd); check("R12 command wins", rd, 32'h4);

    // R1: reset clears counters
    command(1'b0, 7'd20, 1'b1, e);
    do_reset();
    command(1'b0, 7'd20, 1'b0, e); check("R1 counter cleared", 32'(e), 1);

    finish_run();
  end
endmodule